// File: doc/BRIEF.md
# Privilege Mode and Segment Decoder

This block sits in front of an address translation unit. From a handful of processor control bits (a debug flag, a two-bit privilege field, an exception-level bit and an error-level bit) it works out the privilege level in force. It then places a 32-bit virtual address in one of five fixed segments, checks that the privilege level may reach that segment, and gives one of three results: an address error, a request to translate the address, or a physical address formed directly from the virtual one together with a cache attribute.

Most of the logic is combinational. A parameter chooses whether all outputs pass through one register stage or come straight from the logic. A separate flag reports when a debug-mode access falls inside a small, exactly bounded debug window. The translation buffer is outside this block.

Top module: `addr_seg_decode`

## Requirements
- R1: The resolved mode is kernel (mode_o = 2'b00) when dbg_i is 0 and at least one of these holds: priv_i is 2'b00, exl_i is 1, or erl_i is 1.
- R2: With dbg_i, exl_i and erl_i all 0, priv_i = 2'b01 gives supervisor (mode_o = 2'b01), and priv_i = 2'b10 or 2'b11 gives user (mode_o = 2'b10).
- R3: When dbg_i is 1, mode_o is 2'b11 (debug) whatever the other bits are, and accesses have the same segment rights as kernel mode.
- R4: User mode reaches only addresses whose bit 31 is 0. Any other address gives addr_err_o = 1.
- R5: Supervisor mode reaches the low segment (bit 31 = 0) and the segment where bits 31..29 are 3'b110. Bits 31..29 of 3'b100, 3'b101 or 3'b111 give an address error.
- R6: Kernel and debug modes reach every segment. The low segment (when erl_i is 0), the 3'b110 segment and the 3'b111 segment give mapped_o = 1.
- R7: The 3'b100 segment is unmapped. Its physical address is the virtual address with bits 31..29 cleared, cattr_o equals kattr_i, and uncached_o is 0.
- R8: The 3'b101 segment is unmapped. Its physical address is the virtual address with bits 31..29 cleared, uncached_o is 1, and cattr_o is the uncached code 3'b010.
- R9: While erl_i is 1, the low segment is unmapped and uncached. paddr_o equals the virtual address, uncached_o is 1, and cattr_o is 3'b010.
- R10: dbg_hit_o is 1 only when dbg_i is 1 and the address lies in 0xFF20_0000 to 0xFF3F_FFFF inclusive. Addresses 0xFF1F_FFFF and 0xFF40_0000 and above give 0, and so does any address when dbg_i is 0.
- R11: addr_err_o and mapped_o are never both 1. Both are 0 on an unmapped hit. When either is 1, paddr_o, cattr_o and uncached_o are all 0.
- R12: With REG_OUT = 1, every output reflects the inputs sampled at the previous rising clock edge. A synchronous reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| dbg_i | input | 1 | Debug mode active |
| priv_i | input | 2 | Privilege field: 00 kernel, 01 supervisor, 10/11 user |
| exl_i | input | 1 | Exception level set |
| erl_i | input | 1 | Error level set |
| kattr_i | input | 3 | Cache attribute for the cached unmapped kernel segment |
| vaddr_i | input | 32 | Virtual address |
| mode_o | output | 2 | Resolved mode: 00 kernel, 01 supervisor, 10 user, 11 debug |
| addr_err_o | output | 1 | Access not allowed in the resolved mode |
| mapped_o | output | 1 | Address must be translated |
| paddr_o | output | 32 | Physical address for an unmapped hit |
| uncached_o | output | 1 | Access is forced uncached |
| cattr_o | output | 3 | Cache attribute for an unmapped hit |
| dbg_hit_o | output | 1 | Debug-mode access inside the debug window |

## Verification
The bench builds the block with REG_OUT = 1 and the default window bounds 0xFF20_0000 and 0xFF3F_FFFF. The register stage then puts the one-cycle latency and the reset values within reach of the checks. The default bounds let the four addresses on either side of both window edges be tried exactly. With the 3-bit attribute width, a non-default kernel attribute can be told apart from the forced uncached code.

// File: rtl/seg_dec_pkg.sv
package seg_dec_pkg;
  localparam int VA_W   = 32;
  localparam int ATTR_W = 3;

  typedef enum logic [1:0] {
    MODE_KERNEL = 2'b00,
    MODE_SUPER  = 2'b01,
    MODE_USER   = 2'b10,
    MODE_DEBUG  = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    SEG_LOW  = 3'd0,
    SEG_KUNC = 3'd1,
    SEG_KCAC = 3'd2,
    SEG_SUP  = 3'd3,
    SEG_KMAP = 3'd4
  } seg_e;

  typedef struct packed {
    mode_e             mode;
    logic              err;
    logic              mapped;
    logic [VA_W-1:0]   paddr;
    logic              unc;
    logic [ATTR_W-1:0] cattr;
    logic              dbg_hit;
  } dec_out_t;
endpackage

// File: rtl/priv_mode_resolve.sv
module priv_mode_resolve
  import seg_dec_pkg::*;
(
  input  logic       dbg,
  input  logic [1:0] priv,
  input  logic       exl,
  input  logic       erl,
  output mode_e      mode
);
  always_comb begin
    if (dbg)                              mode = MODE_DEBUG;
    else if (exl || erl || priv == 2'b00) mode = MODE_KERNEL;
    else if (priv == 2'b01)               mode = MODE_SUPER;
    else                                  mode = MODE_USER;
  end
endmodule

// File: rtl/seg_classify.sv
module seg_classify
  import seg_dec_pkg::*;
#(
  parameter logic [VA_W-1:0] WIN_LO = 32'hFF20_0000,
  parameter logic [VA_W-1:0] WIN_HI = 32'hFF3F_FFFF
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic            dbg,
  output seg_e            seg,
  output logic            win_hit
);
  localparam int SEL_LSB = VA_W - 3;

  always_comb begin
    unique casez (vaddr[VA_W-1:SEL_LSB])
      3'b0??:  seg = SEG_LOW;
      3'b100:  seg = SEG_KCAC;
      3'b101:  seg = SEG_KUNC;
      3'b110:  seg = SEG_SUP;
      default: seg = SEG_KMAP;
    endcase
  end

  assign win_hit = dbg && (vaddr >= WIN_LO) && (vaddr <= WIN_HI);
endmodule

// File: rtl/seg_access_map.sv
module seg_access_map
  import seg_dec_pkg::*;
#(
  parameter logic [ATTR_W-1:0] UNC_CODE = 3'b010
) (
  input  mode_e             mode,
  input  seg_e              seg,
  input  logic              erl,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [ATTR_W-1:0] kattr,
  output logic              err,
  output logic              mapped,
  output logic [VA_W-1:0]   paddr,
  output logic              unc,
  output logic [ATTR_W-1:0] cattr
);
  localparam int OFF_W = VA_W - 3;

  logic allowed;

  always_comb begin
    unique case (mode)
      MODE_USER:  allowed = (seg == SEG_LOW);
      MODE_SUPER: allowed = (seg == SEG_LOW) || (seg == SEG_SUP);
      default:    allowed = 1'b1;
    endcase
  end

  always_comb begin
    err    = 1'b0;
    mapped = 1'b0;
    paddr  = '0;
    unc    = 1'b0;
    cattr  = '0;
    if (!allowed) begin
      err = 1'b1;
    end else begin
      unique case (seg)
        SEG_KCAC: begin
          paddr = {3'b000, vaddr[OFF_W-1:0]};
          cattr = kattr;
        end
        SEG_KUNC: begin
          paddr = {3'b000, vaddr[OFF_W-1:0]};
          unc   = 1'b1;
          cattr = UNC_CODE;
        end
        SEG_LOW: begin
          if (erl) begin
            paddr = vaddr;
            unc   = 1'b1;
            cattr = UNC_CODE;
          end else begin
            mapped = 1'b1;
          end
        end
        default: mapped = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/addr_seg_decode.sv
module addr_seg_decode
  import seg_dec_pkg::*;
#(
  parameter bit                REG_OUT  = 1'b1,
  parameter logic [ATTR_W-1:0] UNC_CODE = 3'b010,
  parameter logic [VA_W-1:0]   WIN_LO   = 32'hFF20_0000,
  parameter logic [VA_W-1:0]   WIN_HI   = 32'hFF3F_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_i,
  input  logic [1:0]        priv_i,
  input  logic              exl_i,
  input  logic              erl_i,
  input  logic [ATTR_W-1:0] kattr_i,
  input  logic [VA_W-1:0]   vaddr_i,
  output logic [1:0]        mode_o,
  output logic              addr_err_o,
  output logic              mapped_o,
  output logic [VA_W-1:0]   paddr_o,
  output logic              uncached_o,
  output logic [ATTR_W-1:0] cattr_o,
  output logic              dbg_hit_o
);
  mode_e    mode_c;
  seg_e     seg_c;
  dec_out_t nxt, cur;

  priv_mode_resolve u_mode (
    .dbg(dbg_i), .priv(priv_i), .exl(exl_i), .erl(erl_i), .mode(mode_c)
  );

  seg_classify #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_seg (
    .vaddr(vaddr_i), .dbg(dbg_i), .seg(seg_c), .win_hit(nxt.dbg_hit)
  );

  seg_access_map #(.UNC_CODE(UNC_CODE)) u_map (
    .mode(mode_c), .seg(seg_c), .erl(erl_i), .vaddr(vaddr_i), .kattr(kattr_i),
    .err(nxt.err), .mapped(nxt.mapped), .paddr(nxt.paddr),
    .unc(nxt.unc), .cattr(nxt.cattr)
  );

  assign nxt.mode = mode_c;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
      end
    end else begin : g_comb
      assign cur = nxt;
    end
  endgenerate

  assign mode_o     = cur.mode;
  assign addr_err_o = cur.err;
  assign mapped_o   = cur.mapped;
  assign paddr_o    = cur.paddr;
  assign uncached_o = cur.unc;
  assign cattr_o    = cur.cattr;
  assign dbg_hit_o  = cur.dbg_hit;

  // R11: error and mapped never together
  p_err_mapped_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(nxt.err && nxt.mapped));
  // R4: user mode blocked above the low segment
  p_user_low_only_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_c == MODE_USER && vaddr_i[VA_W-1]) |-> nxt.err);
  // R8: the uncached kernel segment always reaches low physical space uncached
  p_kunc_forced_r8: assert property (@(posedge clk) disable iff (rst)
    (!nxt.err && vaddr_i[VA_W-1:VA_W-3] == 3'b101) |-> (nxt.unc && nxt.paddr[VA_W-1:VA_W-3] == 3'b000));
  // R10: debug window hit needs debug mode
  p_win_needs_dbg_r10: assert property (@(posedge clk) disable iff (rst)
    nxt.dbg_hit |-> (mode_c == MODE_DEBUG));
  // R12: registered outputs follow the previous cycle's decode
  p_reg_latency_r12: assert property (@(posedge clk) disable iff (rst)
    (REG_OUT && !$past(rst)) |-> (cur == $past(nxt)));
endmodule

// File: tb/addr_seg_decode_test.sv
`timescale 1ns/1ps
module addr_seg_decode_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dbg_i = 1'b0;
  logic [1:0]  priv_i = 2'b00;
  logic        exl_i = 1'b0;
  logic        erl_i = 1'b0;
  logic [2:0]  kattr_i = 3'b000;
  logic [31:0] vaddr_i = 32'h0;
  logic [1:0]  mode_o;
  logic        addr_err_o, mapped_o, uncached_o, dbg_hit_o;
  logic [31:0] paddr_o;
  logic [2:0]  cattr_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addr_seg_decode uut (
    .clk(clk), .rst(rst), .dbg_i(dbg_i), .priv_i(priv_i), .exl_i(exl_i),
    .erl_i(erl_i), .kattr_i(kattr_i), .vaddr_i(vaddr_i), .mode_o(mode_o),
    .addr_err_o(addr_err_o), .mapped_o(mapped_o), .paddr_o(paddr_o),
    .uncached_o(uncached_o), .cattr_o(cattr_o), .dbg_hit_o(dbg_hit_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge capture, sample at the next falling edge
  task automatic apply(logic d, logic [1:0] p, logic x, logic e, logic [2:0] ka, logic [31:0] va);
    @(negedge clk);
    dbg_i = d; priv_i = p; exl_i = x; erl_i = e; kattr_i = ka; vaddr_i = va;
    @(negedge clk);
  endtask

  task automatic chk_unmapped(string req, logic [31:0] pa, logic u, logic [2:0] ca);
    chk({req, " err"}, {31'b0, addr_err_o}, 32'd0);
    chk({req, " mapped"}, {31'b0, mapped_o}, 32'd0);
    chk({req, " paddr"}, paddr_o, pa);
    chk({req, " unc"}, {31'b0, uncached_o}, {31'b0, u});
    chk({req, " cattr"}, {29'b0, cattr_o}, {29'b0, ca});
  endtask

  task automatic chk_outcome(string req, logic e, logic m);
    chk({req, " err"}, {31'b0, addr_err_o}, {31'b0, e});
    chk({req, " mapped"}, {31'b0, mapped_o}, {31'b0, m});
    chk("R11 zero paddr", paddr_o, 32'd0);
    chk("R11 zero unc", {31'b0, uncached_o}, 32'd0);
    chk("R11 zero cattr", {29'b0, cattr_o}, 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R12 reset mode", {30'b0, mode_o}, 32'd0);
    chk("R12 reset err", {31'b0, addr_err_o}, 32'd0);
    chk("R12 reset mapped", {31'b0, mapped_o}, 32'd0);
    chk("R12 reset paddr", paddr_o, 32'd0);
    chk("R12 reset dbg", {31'b0, dbg_hit_o}, 32'd0);
  endtask

  task automatic t_modes;
    apply(0, 2'b00, 0, 0, 0, 0); chk("R1 field 00", {30'b0, mode_o}, 32'd0);
    apply(0, 2'b10, 1, 0, 0, 0); chk("R1 exl", {30'b0, mode_o}, 32'd0);
    apply(0, 2'b01, 0, 1, 0, 0); chk("R1 erl", {30'b0, mode_o}, 32'd0);
    apply(0, 2'b01, 0, 0, 0, 0); chk("R2 super", {30'b0, mode_o}, 32'd1);
    apply(0, 2'b10, 0, 0, 0, 0); chk("R2 user", {30'b0, mode_o}, 32'd2);
    apply(0, 2'b11, 0, 0, 0, 0); chk("R2 field 11 user", {30'b0, mode_o}, 32'd2);
    apply(1, 2'b10, 0, 0, 0, 0); chk("R3 debug", {30'b0, mode_o}, 32'd3);
  endtask

  task automatic t_user;
    apply(0, 2'b10, 0, 0, 3'd3, 32'h1234_5678); chk_outcome("R4 user low", 0, 1);
    apply(0, 2'b10, 0, 0, 3'd3, 32'h8000_0000); chk_outcome("R4 user kseg", 1, 0);
    apply(0, 2'b11, 0, 0, 3'd3, 32'hC000_0000); chk_outcome("R4 user 11 sup seg", 1, 0);
  endtask

  task automatic t_super;
    apply(0, 2'b01, 0, 0, 3'd3, 32'hC000_1000); chk_outcome("R5 sup seg", 0, 1);
    apply(0, 2'b01, 0, 0, 3'd3, 32'h7FFF_FFFF); chk_outcome("R5 sup low", 0, 1);
    apply(0, 2'b01, 0, 0, 3'd3, 32'hA000_0000); chk_outcome("R5 sup kunc", 1, 0);
    apply(0, 2'b01, 0, 0, 3'd3, 32'hE000_0000); chk_outcome("R5 sup kmap", 1, 0);
  endtask

  task automatic t_kernel;
    apply(0, 2'b00, 0, 0, 3'd3, 32'hE000_0010); chk_outcome("R6 kmap", 0, 1);
    apply(0, 2'b00, 0, 0, 3'd3, 32'h0000_1000); chk_outcome("R6 low", 0, 1);
    apply(0, 2'b00, 0, 0, 3'd3, 32'hDFFF_FFFF); chk_outcome("R6 sup seg", 0, 1);
    apply(1, 2'b10, 0, 0, 3'd3, 32'hE000_0000); chk_outcome("R6 debug kmap", 0, 1);
  endtask

  task automatic t_kcac;
    apply(0, 2'b00, 0, 0, 3'd3, 32'h8123_4567); chk_unmapped("R7 kcac", 32'h0123_4567, 0, 3'd3);
    apply(0, 2'b10, 1, 0, 3'd5, 32'h9FFF_FFFF); chk_unmapped("R7 kcac exl", 32'h1FFF_FFFF, 0, 3'd5);
  endtask

  task automatic t_kunc;
    apply(0, 2'b00, 0, 0, 3'd3, 32'hBFFF_FFFC); chk_unmapped("R8 kunc", 32'h1FFF_FFFC, 1, 3'd2);
    apply(1, 2'b11, 0, 0, 3'd3, 32'hA000_0040); chk_unmapped("R8 kunc debug", 32'h0000_0040, 1, 3'd2);
  endtask

  task automatic t_erl;
    apply(0, 2'b10, 0, 1, 3'd3, 32'h7000_0004); chk_unmapped("R9 erl low", 32'h7000_0004, 1, 3'd2);
    chk("R9 erl mode", {30'b0, mode_o}, 32'd0);
    apply(0, 2'b10, 0, 1, 3'd3, 32'hE000_0000); chk_outcome("R9 erl kmap still mapped", 0, 1);
  endtask

  task automatic t_dbgwin;
    apply(1, 2'b00, 0, 0, 0, 32'hFF1F_FFFF); chk("R10 below", {31'b0, dbg_hit_o}, 32'd0);
    apply(1, 2'b00, 0, 0, 0, 32'hFF20_0000); chk("R10 low edge", {31'b0, dbg_hit_o}, 32'd1);
    apply(1, 2'b00, 0, 0, 0, 32'hFF3F_FFFF); chk("R10 high edge", {31'b0, dbg_hit_o}, 32'd1);
    apply(1, 2'b00, 0, 0, 0, 32'hFF40_0000); chk("R10 above", {31'b0, dbg_hit_o}, 32'd0);
    apply(1, 2'b00, 0, 0, 0, 32'hFFFF_FFF0); chk("R10 top", {31'b0, dbg_hit_o}, 32'd0);
    apply(0, 2'b00, 0, 0, 0, 32'hFF30_0000); chk("R10 no debug", {31'b0, dbg_hit_o}, 32'd0);
  endtask

  task automatic t_latency;
    apply(0, 2'b00, 0, 0, 3'd3, 32'h8000_0100);
    @(negedge clk);
    vaddr_i = 32'hA000_0200;
    #1 chk("R12 holds before edge", paddr_o, 32'h0000_0100);
    @(negedge clk);
    chk("R12 after edge", paddr_o, 32'h0000_0200);
    chk("R12 after edge unc", {31'b0, uncached_o}, 32'd1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    @(negedge clk) rst = 1'b0;
    t_modes;
    t_user;
    t_super;
    t_kernel;
    t_kcac;
    t_kunc;
    t_erl;
    t_dbgwin;
    t_latency;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule